// File: doc/BRIEF.md
# Link Self-Test Error Monitor

This block is the receive-side checker for an at-speed self-test of a serial link. While the test enable is held high, it takes incoming test words from a stream interface. It seeds a local PRBS-7 reference from the first word it sees and then predicts every following word. Each frame that holds a word differing from the prediction is flagged on the `test_ok` output. The flag is a low pulse lasting half a test-clock period.

When the enable drops, `test_ok` stops pulsing and shows the overall verdict of the test just finished. It is high if no frame was errored and low otherwise. It keeps that verdict until the next test starts or reset is applied. A saturating count of errored frames is presented alongside. The test clock is either the external pixel clock or an internal oscillator of about 33 MHz, chosen by a select pin.

The input stream never stalls: `in_ready` is constantly high, so the sender cannot be back-pressured. A word is consumed on every test-clock rising edge at which `in_valid` is high.

Top module: `link_selftest_mon`

## Requirements
- R1: After reset, `test_ok` is 1, `err_frames` is 0 and `in_ready` is 1.
- R2: `in_ready` is always 1. A word is taken only on a rising test-clock edge where `selftest_en`, `link_locked` and `in_valid` are all high. A cycle without `in_valid` never changes the count.
- R3: The pattern is the serial sequence b[n] = b[n-6] XOR b[n-7]. Each word carries WORD_W consecutive bits, with the oldest bit in the MSB. The first word taken after a start (or after re-lock) seeds the reference and is not compared. Every later word is compared with the prediction, and the prediction always advances from the expected value.
- R4: A frame ends with the word taken with `in_last` high. If any compared word of that frame mismatched, `test_ok` is low during the low phase of the next test-clock cycle and high during its high phase. During a test, `test_ok` is otherwise high.
- R5: In any test cycle where `link_locked` is low, incoming words and frame strobes are ignored, and the next word taken after lock returns re-seeds the reference.
- R6: From the first cycle after `selftest_en` is sampled low, `test_ok` is steadily 1 if the last test saw no errored frame and 0 if it saw one. This verdict holds until the next start or reset.
- R7: `err_frames` counts errored frames during a test and saturates at 2^CNT_W-1. It holds its value while idle.
- R8: `clk_src` = 0 selects `clk_pix` and 1 selects `clk_osc`. All sampling and pulse shaping use the selected clock.
- R9: The first rising edge with `selftest_en` high after it was low clears the count and verdict, whatever the previous test produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pix | input | 1 | External pixel clock |
| clk_osc | input | 1 | Internal oscillator clock |
| clk_src | input | 1 | Test clock select: 0 pixel, 1 oscillator |
| rst_n | input | 1 | Asynchronous active-low reset (also used for power-down) |
| selftest_en | input | 1 | Test runs while high |
| link_locked | input | 1 | Receiver lock; words are ignored while low |
| in_valid | input | 1 | Test word valid |
| in_ready | output | 1 | Always high; no back-pressure |
| in_data | input | WORD_W | Received test word |
| in_last | input | 1 | Marks the last word of a frame |
| test_ok | output | 1 | Per-frame error pulse during a test, verdict after it |
| err_frames | output | CNT_W | Saturating errored-frame count |

## Verification
The properties assume that `clk_src` only changes while reset is held. They also assume that the word which seeds the reference after a start or re-lock is a genuine member of the sequence, since a corrupted seed would make every later word mismatch. The stimulus switches the clock source only inside a reset pulse. It corrupts words only once the reference is seeded, and it skips part of the sequence during a lock loss so that a missing re-seed would show up.

// File: rtl/lst_pkg.sv
package lst_pkg;
  // Test clock sources
  typedef enum logic {
    SRC_PIXEL = 1'b0,
    SRC_OSC   = 1'b1
  } clk_src_e;

  // PRBS-7 feedback taps on a history vector where bit 0 is the newest bit
  localparam int PRBS_LEN    = 7;
  localparam int PRBS_TAP_HI = 6;
  localparam int PRBS_TAP_LO = 5;

  function automatic logic prbs7_fb(input logic [PRBS_LEN-1:0] hist);
    return hist[PRBS_TAP_HI] ^ hist[PRBS_TAP_LO];
  endfunction
endpackage

// File: rtl/lst_clk_pick.sv
module lst_clk_pick (
  input  logic clk_pix,
  input  logic clk_osc,
  input  logic clk_src,
  output logic test_clk
);
  // Source may only change while reset is held
  assign test_clk = (lst_pkg::clk_src_e'(clk_src) == lst_pkg::SRC_OSC) ? clk_osc : clk_pix;
endmodule

// File: rtl/lst_prbs_ref.sv
module lst_prbs_ref #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              take,
  input  logic              resync,
  input  logic [WORD_W-1:0] word,
  output logic              mismatch
);
  localparam int HL = lst_pkg::PRBS_LEN;

  logic              seeded_q;
  logic              seeded_eff;
  logic [HL-1:0]     hist_q;
  logic [WORD_W-1:0] expect_w;
  logic [WORD_W:0][HL-1:0] chain;

  // Unroll the serial generator across one word, oldest bit into the MSB
  assign chain[0] = hist_q;
  for (genvar i = 0; i < WORD_W; i++) begin : g_step
    logic nb;
    assign nb                 = lst_pkg::prbs7_fb(chain[i]);
    assign chain[i+1]         = {chain[i][HL-2:0], nb};
    assign expect_w[WORD_W-1-i] = nb;
  end

  assign seeded_eff = seeded_q & ~start;
  assign mismatch   = take & seeded_eff & (word != expect_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seeded_q <= 1'b0;
      hist_q   <= '0;
    end else if (resync) begin
      seeded_q <= 1'b0;
    end else if (take) begin
      seeded_q <= 1'b1;
      // newest seven bits of the word become the history
      hist_q   <= seeded_eff ? expect_w[HL-1:0] : word[HL-1:0];
    end else if (start) begin
      seeded_q <= 1'b0;
    end
  end
endmodule

// File: rtl/lst_frame_tally.sv
module lst_frame_tally #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             take,
  input  logic             last,
  input  logic             mismatch,
  output logic             frame_flag,
  output logic             result_bad,
  output logic [CNT_W-1:0] err_frames
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             acc_q, bad_q, flag_q;
  logic [CNT_W-1:0] cnt_q;
  logic             acc_eff;
  logic [CNT_W-1:0] cnt_eff;
  logic             frame_bad;

  assign acc_eff   = acc_q & ~start;
  assign cnt_eff   = start ? '0 : cnt_q;
  assign frame_bad = acc_eff | mismatch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= 1'b0;
      bad_q  <= 1'b0;
      flag_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      flag_q <= 1'b0;
      if (start) begin
        acc_q <= 1'b0;
        bad_q <= 1'b0;
        cnt_q <= '0;
      end
      if (take) begin
        if (last) begin
          acc_q <= 1'b0;
          if (frame_bad) begin
            flag_q <= 1'b1;
            bad_q  <= 1'b1;
            if (cnt_eff != CNT_MAX) cnt_q <= cnt_eff + CNT_ONE;
          end
        end else if (mismatch) begin
          acc_q <= 1'b1;
        end
      end
    end
  end

  assign frame_flag = flag_q;
  assign result_bad = bad_q;
  assign err_frames = cnt_q;
endmodule

// File: rtl/lst_ok_drive.sv
module lst_ok_drive (
  input  logic test_clk,
  input  logic test_active,
  input  logic frame_flag,
  input  logic result_bad,
  output logic test_ok
);
  // During a test the flag can only pull the output low in the clock's low phase
  assign test_ok = test_active ? (~frame_flag | test_clk) : ~result_bad;
endmodule

// File: rtl/link_selftest_mon.sv
module link_selftest_mon #(
  parameter int WORD_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk_pix,
  input  logic              clk_osc,
  input  logic              clk_src,
  input  logic              rst_n,
  input  logic              selftest_en,
  input  logic              link_locked,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic              in_last,
  output logic              test_ok,
  output logic [CNT_W-1:0]  err_frames
);
  logic test_clk;
  logic en_q;
  logic start, take, resync;
  logic mismatch, frame_flag, result_bad;

  lst_clk_pick u_clk (
    .clk_pix (clk_pix),
    .clk_osc (clk_osc),
    .clk_src (clk_src),
    .test_clk(test_clk)
  );

  always_ff @(posedge test_clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= selftest_en;
  end

  assign start    = selftest_en & ~en_q;
  assign take     = selftest_en & link_locked & in_valid;
  assign resync   = selftest_en & ~link_locked;
  assign in_ready = 1'b1;

  lst_prbs_ref #(.WORD_W(WORD_W)) u_ref (
    .clk     (test_clk),
    .rst_n   (rst_n),
    .start   (start),
    .take    (take),
    .resync  (resync),
    .word    (in_data),
    .mismatch(mismatch)
  );

  lst_frame_tally #(.CNT_W(CNT_W)) u_tally (
    .clk       (test_clk),
    .rst_n     (rst_n),
    .start     (start),
    .take      (take),
    .last      (in_last),
    .mismatch  (mismatch),
    .frame_flag(frame_flag),
    .result_bad(result_bad),
    .err_frames(err_frames)
  );

  lst_ok_drive u_ok (
    .test_clk   (test_clk),
    .test_active(en_q),
    .frame_flag (frame_flag),
    .result_bad (result_bad),
    .test_ok    (test_ok)
  );
endmodule

// File: rtl/link_selftest_mon_sva.sv
module link_selftest_mon_sva #(
  parameter int CNT_W = 16
) (
  input logic             test_clk,
  input logic             rst_n,
  input logic             selftest_en,
  input logic             link_locked,
  input logic             in_valid,
  input logic             test_ok,
  input logic [CNT_W-1:0] err_frames
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  AST_START_CLEARS: assert property (@(posedge test_clk) disable iff (!rst_n)
    $rose(selftest_en) |=> (err_frames == '0)); // R9

  AST_IDLE_FROZEN: assert property (@(posedge test_clk) disable iff (!rst_n)
    !$past(selftest_en) |-> $stable(err_frames)); // R7

  AST_CNT_STEP: assert property (@(posedge test_clk) disable iff (!rst_n)
    ($past(selftest_en) && $past(selftest_en, 2)) |->
      ((err_frames == $past(err_frames)) || (err_frames == $past(err_frames) + CNT_ONE))); // R7

  AST_PULSE_ON_COUNT: assert property (@(posedge test_clk) disable iff (!rst_n)
    ($past(selftest_en) && $past(selftest_en, 2) && (err_frames != $past(err_frames))) |-> !test_ok); // R4

  AST_QUIET_WHEN_CLEAN: assert property (@(posedge test_clk) disable iff (!rst_n)
    ($past(selftest_en) && $past(selftest_en, 2) && (err_frames == $past(err_frames))
      && (err_frames != CNT_MAX)) |-> test_ok); // R4

  AST_IDLE_VERDICT: assert property (@(posedge test_clk) disable iff (!rst_n)
    !$past(selftest_en) |-> (test_ok == (err_frames == '0))); // R6

  AST_UNLOCKED_IGNORED: assert property (@(posedge test_clk) disable iff (!rst_n)
    ($past(selftest_en) && $past(selftest_en, 2) && !$past(link_locked)) |-> $stable(err_frames)); // R5

  AST_NO_VALID_NO_COUNT: assert property (@(posedge test_clk) disable iff (!rst_n)
    ($past(selftest_en) && $past(selftest_en, 2) && !$past(in_valid)) |-> $stable(err_frames)); // R2
endmodule

bind link_selftest_mon link_selftest_mon_sva #(.CNT_W(CNT_W)) u_sva (
  .test_clk   (test_clk),
  .rst_n      (rst_n),
  .selftest_en(selftest_en),
  .link_locked(link_locked),
  .in_valid   (in_valid),
  .test_ok    (test_ok),
  .err_frames (err_frames)
);

// File: tb/link_selftest_mon_tb_top.sv
module link_selftest_mon_tb_top;
  localparam int WW   = 8;
  localparam int CW   = 3;
  localparam int CMAX = (1 << CW) - 1;

  logic clk_pix = 1'b0, clk_osc = 1'b0, clk_src = 1'b0, rst_n = 1'b0;
  logic selftest_en = 1'b0, link_locked = 1'b1, in_valid = 1'b0, in_last = 1'b0;
  logic tb_bad = 1'b0;
  logic [WW-1:0] in_data = '0;
  logic in_ready, test_ok;
  logic [CW-1:0] err_frames;
  logic tclk;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  bit gen_q[$];

  // behavioural reference state
  bit m_en, m_seed, m_acc, m_flag, m_bad;
  int m_cnt;

  always #10 clk_pix = ~clk_pix;   // 50 MHz
  always #15 clk_osc = ~clk_osc;   // about 33 MHz
  assign tclk = clk_src ? clk_osc : clk_pix;

  link_selftest_mon #(.WORD_W(WW), .CNT_W(CW)) dut_i (
    .clk_pix(clk_pix), .clk_osc(clk_osc), .clk_src(clk_src), .rst_n(rst_n),
    .selftest_en(selftest_en), .link_locked(link_locked),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .test_ok(test_ok), .err_frames(err_frames)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // serial PRBS: next bit = b[n-6] ^ b[n-7]; oldest bit of a word in the MSB
  function automatic logic [WW-1:0] gen_word();
    logic [WW-1:0] w;
    for (int i = 0; i < WW; i++) begin
      bit nb;
      nb = gen_q[0] ^ gen_q[1];
      gen_q.push_back(nb);
      void'(gen_q.pop_front());
      w[WW-1-i] = nb;
    end
    return w;
  endfunction

  // reference model, one step per test-clock edge
  always @(posedge tclk) begin
    if (!rst_n) begin
      m_en = 0; m_seed = 0; m_acc = 0; m_flag = 0; m_bad = 0; m_cnt = 0;
    end else begin
      m_flag = 0;
      if (selftest_en) begin
        if (!m_en) begin m_seed = 0; m_acc = 0; m_cnt = 0; m_bad = 0; end
        if (!link_locked) m_seed = 0;
        else if (in_valid) begin
          bit e;
          e = m_seed && tb_bad;
          m_seed = 1;
          if (in_last) begin
            if (m_acc || e) begin
              m_flag = 1; m_bad = 1;
              if (m_cnt < CMAX) m_cnt++;
            end
            m_acc = 0;
          end else if (e) m_acc = 1;
        end
      end
      m_en = selftest_en;
    end
  end

  always @(posedge tclk) begin
    #4;
    if (rst_n && !done) begin
      chk("R2 ready high", int'(in_ready), 1);
      chk(m_en ? "R4 ok in high phase" : "R6 held verdict", int'(test_ok), m_en ? 1 : int'(!m_bad));
      chk("R7 errored frame count", int'(err_frames), m_cnt);
    end
  end

  always @(negedge tclk) begin
    #4;
    if (rst_n && !done)
      chk(m_en ? "R4 ok in low phase" : "R6 held verdict", int'(test_ok), m_en ? int'(!m_flag) : int'(!m_bad));
  end

  task automatic cyc(input logic v, input logic [WW-1:0] d, input logic l, input logic b, input logic lk);
    @(negedge tclk);
    in_valid = v; in_data = d; in_last = l; tb_bad = b; link_locked = lk;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, '0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic frame(input int n, input int bad_a, input int bad_b, input bit gap);
    for (int i = 0; i < n; i++) begin
      logic [WW-1:0] w;
      bit b;
      w = gen_word();
      b = (i == bad_a) || (i == bad_b);
      cyc(1'b1, b ? (w ^ 8'h24) : w, i == n - 1, b, 1'b1);
      if (gap && i == 0) cyc(1'b0, '0, 1'b0, 1'b0, 1'b1);
    end
  endtask

  task automatic start_test();
    @(negedge tclk);
    selftest_en = 1; in_valid = 0; in_last = 0; tb_bad = 0; link_locked = 1;
  endtask

  task automatic stop_test();
    @(negedge tclk);
    selftest_en = 0; in_valid = 0; in_last = 0; tb_bad = 0;
  endtask

  task automatic at_high();
    @(posedge tclk); #6;
  endtask

  initial begin
    gen_q = '{1, 0, 0, 1, 1, 0, 1};
    repeat (3) @(posedge clk_pix);
    @(negedge tclk); rst_n = 1;
    at_high();
    chk("R1 ok after reset", int'(test_ok), 1);
    chk("R1 count after reset", int'(err_frames), 0);
    chk("R1 ready after reset", int'(in_ready), 1);

    // errored and clean frames, with valid gaps
    start_test();
    at_high();
    chk("R9 count zero at start", int'(err_frames), 0);
    frame(4, -1, -1, 0);
    frame(4, 2, -1, 1);
    frame(4, -1, -1, 0);
    frame(3, 0, 2, 0);
    frame(5, -1, -1, 1);
    stop_test(); idle(3); at_high();
    chk("R3 mismatching frames counted", int'(err_frames), 2);
    chk("R6 verdict low after errors", int'(test_ok), 0);
    idle(5); at_high();
    chk("R6 verdict held while idle", int'(test_ok), 0);

    // clean test after a failing one
    start_test();
    at_high();
    chk("R9 restart clears count", int'(err_frames), 0);
    chk("R9 restart ok high", int'(test_ok), 1);
    frame(4, -1, -1, 0);
    frame(2, -1, -1, 1);
    stop_test(); idle(2); at_high();
    chk("R6 clean verdict high", int'(test_ok), 1);

    // lock loss: garbage and a frame strobe while unlocked, sequence skips ahead
    start_test();
    frame(4, -1, -1, 0);
    for (int i = 0; i < 5; i++) cyc(1'b1, 8'hA5, i == 4, 1'b1, 1'b0);
    repeat (3) void'(gen_word());
    frame(4, -1, -1, 0);
    frame(4, 1, -1, 0);
    stop_test(); idle(2); at_high();
    chk("R5 unlocked words ignored and reseeded", int'(err_frames), 1);

    // saturation of the counter
    start_test();
    frame(2, -1, -1, 0);
    for (int i = 0; i < CMAX + 3; i++) frame(2, 1, -1, 0);
    stop_test(); idle(2); at_high();
    chk("R7 count saturates", int'(err_frames), CMAX);
    chk("R6 verdict after saturation", int'(test_ok), 0);

    // oscillator clock, switched inside reset
    @(negedge tclk); rst_n = 0;
    #7 clk_src = 1;
    #40;
    @(negedge tclk); rst_n = 1;
    at_high();
    chk("R8 reset state on oscillator", int'(err_frames), 0);
    start_test();
    frame(3, -1, -1, 0);
    frame(3, -1, 1, 0);
    cyc(1'b0, '0, 1'b0, 1'b0, 1'b1);
    #4;
    chk("R8 low phase pulse on oscillator", int'(test_ok), 0);
    @(posedge tclk); #4;
    chk("R8 high phase after pulse", int'(test_ok), 1);
    stop_test(); idle(2); at_high();
    chk("R8 count on oscillator", int'(err_frames), 1);
    chk("R8 verdict on oscillator", int'(test_ok), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule